// File: doc/BRIEF.md
# Mailbox Transmit Controller

This block is the sending half of an inter-processor mailbox. A local bus master stages a 64-bit message through a 32-bit register port: first the low word, then the high word, then the number of the destination core, then a trigger write. The trigger moves the staged message into that destination's own pending slot. A slot stays occupied until its core takes the message through a per-destination valid/data/fetch handshake.

For every destination the block tracks three flags. A busy flag marks a message that has not been taken yet. An overflow flag records that a trigger was refused because the slot was still occupied. A delivered flag records that the core fetched its message. Software clears the overflow and delivered flags selectively by writing a bit mask. A single maskable interrupt line combines three events: a fetch, a refused trigger, and the first refusal that sets an overflow flag. The line stays latched until software clears it.

Top module: `mbx_send_ctrl`

## Requirements
- R1: After reset the busy, overflow and delivered flags, the staged words, the destination number and the interrupt status are all zero, the interrupt mask reads 3'b111, and `irq_o` is low.
- R2: Writes to offset 0x04 (low word), 0x08 (high word), 0x00 (destination, bits 2:0) and 0x1C (interrupt mask, bits 2:0) read back at the same offsets on the cycle after the write.
- R3: A write of a value with bit 0 set to offset 0x0C, aimed at a destination whose busy flag is clear, copies {high word, low word} into that destination's slot. It also raises that destination's `tgt_valid_o` bit on the next cycle. A write to 0x0C with bit 0 clear has no effect.
- R4: A trigger aimed at a destination whose busy flag is already set leaves that slot's data unchanged, keeps the busy flag set and sets the destination's overflow flag.
- R5: A fetch on a busy destination clears its busy flag and sets its delivered flag at the same clock edge. A fetch on a destination that is not busy is ignored.
- R6: The status word at offset 0x14 reads {8'h00, delivered[7:0], overflow[7:0], busy[7:0]}, with bit n of each field belonging to destination n.
- R7: A write to offset 0x10 clears each delivered flag whose bit is set in data bits 23:16 and each overflow flag whose bit is set in data bits 15:8. Busy flags are not affected. A flag that is set and cleared at the same edge ends up set.
- R8: At the same edge as the flag update, the interrupt status (offset 0x18, bit 0) latches on any unmasked event. The events are: a fetch (mask bit 2), an overflow flag going from 0 to 1 (mask bit 1), and any trigger refused because the destination is busy (mask bit 0). `irq_o` equals the interrupt status bit.
- R9: Writing 1 to bit 0 at offset 0x18 clears the interrupt status. An unmasked event at the same edge wins, and writing 0 does nothing.
- R10: An event that occurs while its source is masked is not remembered: clearing the mask afterwards does not raise the interrupt.
- R11: A trigger and a fetch on the same busy destination in the same cycle refuse the trigger (overflow set, data kept) while completing the fetch. The destination ends up not busy, with its delivered flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| tgt_valid_o | output | 8 | Per-destination message pending (busy flags) |
| tgt_data_o | output | 512 | Per-destination 64-bit message, destination n in bits 64n+63:64n |
| tgt_fetch_i | input | 8 | Per-destination fetch pulse |
| irq_o | output | 1 | Latched interrupt request |

## Verification
The hardest situations to reach are the ones where two actions meet at one clock edge. Examples are a clear write arriving while a fetch sets the same delivered flag, a trigger and a fetch hitting the same occupied slot, and an interrupt clear landing on a new event. The bench reaches them by driving the fetch vector in the same cycle as a register write, so each collision happens exactly at one edge. The overflow-event rule is covered by a second refusal with only that source unmasked, where the interrupt must stay low.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int unsigned FLD_W     = 8;
  localparam int unsigned OFF_ID    = 'h00;
  localparam int unsigned OFF_LO    = 'h04;
  localparam int unsigned OFF_HI    = 'h08;
  localparam int unsigned OFF_TRIG  = 'h0C;
  localparam int unsigned OFF_CLR   = 'h10;
  localparam int unsigned OFF_STS   = 'h14;
  localparam int unsigned OFF_ISTS  = 'h18;
  localparam int unsigned OFF_MASK  = 'h1C;

  // bit 2 delivered, bit 1 overflow, bit 0 blocked (mask register order)
  typedef struct packed {
    logic dlv;
    logic ovf;
    logic blk;
  } mbx_evt_t;
endpackage

// File: rtl/mbx_slot.sv
`timescale 1ns/1ps
module mbx_slot #(
  parameter int unsigned MSG_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             fetch_i,
  input  logic             ovf_clr_i,
  input  logic             dlv_clr_i,
  input  logic [MSG_W-1:0] data_i,
  output logic             busy_o,
  output logic             ovf_o,
  output logic             dlv_o,
  output logic [MSG_W-1:0] data_o,
  output logic             blk_ev_o,
  output logic             ovf_ev_o,
  output logic             dlv_ev_o
);
  logic busy_q, ovf_q, dlv_q;
  logic [MSG_W-1:0] data_q;
  logic accept, drop, take;

  // decisions use the flag state before this edge
  assign accept = trig_i & ~busy_q;
  assign drop   = trig_i & busy_q;
  assign take   = fetch_i & busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ovf_q  <= 1'b0;
      dlv_q  <= 1'b0;
      data_q <= '0;
    end else begin
      busy_q <= (busy_q & ~take) | accept;
      ovf_q  <= (ovf_q & ~ovf_clr_i) | drop;
      dlv_q  <= (dlv_q & ~dlv_clr_i) | take;
      if (accept) data_q <= data_i;
    end
  end

  assign busy_o   = busy_q;
  assign ovf_o    = ovf_q;
  assign dlv_o    = dlv_q;
  assign data_o   = data_q;
  assign blk_ev_o = drop;
  assign ovf_ev_o = drop & ~ovf_q;
  assign dlv_ev_o = take;
endmodule

// File: rtl/mbx_irq.sv
`timescale 1ns/1ps
module mbx_irq
  import mbx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  mbx_evt_t evt_i,
  input  logic     mask_we_i,
  input  mbx_evt_t mask_wdata_i,
  input  logic     clr_i,
  output mbx_evt_t mask_o,
  output logic     irq_o
);
  mbx_evt_t mask_q;
  logic     ists_q;
  logic     hit;

  assign hit = |(evt_i & ~mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      ists_q <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      ists_q <= (ists_q & ~clr_i) | hit;
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = ists_q;
endmodule

// File: rtl/mbx_send_ctrl.sv
`timescale 1ns/1ps
module mbx_send_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_we_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]         reg_wdata_i,
  output logic [DATA_W-1:0]         reg_rdata_o,
  output logic [NUM_TGT-1:0]        tgt_valid_o,
  output logic [NUM_TGT*2*DATA_W-1:0] tgt_data_o,
  input  logic [NUM_TGT-1:0]        tgt_fetch_i,
  output logic                      irq_o
);
  localparam int unsigned ID_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
  localparam int unsigned MSG_W = 2 * DATA_W;

  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] lo_q, hi_q;
  logic wr_id, wr_lo, wr_hi, trig, wr_clr, wr_ists, wr_mask;
  logic [NUM_TGT-1:0] busy_vec, ovf_vec, dlv_vec;
  logic [NUM_TGT-1:0] blk_ev, ovf_ev, dlv_ev;
  mbx_evt_t evt, mask_vec;
  logic [DATA_W-1:0] sts;

  assign wr_id   = reg_we_i && reg_addr_i == ADDR_W'(OFF_ID);
  assign wr_lo   = reg_we_i && reg_addr_i == ADDR_W'(OFF_LO);
  assign wr_hi   = reg_we_i && reg_addr_i == ADDR_W'(OFF_HI);
  assign trig    = reg_we_i && reg_addr_i == ADDR_W'(OFF_TRIG) && reg_wdata_i[0];
  assign wr_clr  = reg_we_i && reg_addr_i == ADDR_W'(OFF_CLR);
  assign wr_ists = reg_we_i && reg_addr_i == ADDR_W'(OFF_ISTS) && reg_wdata_i[0];
  assign wr_mask = reg_we_i && reg_addr_i == ADDR_W'(OFF_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_id) id_q <= reg_wdata_i[ID_W-1:0];
      if (wr_lo) lo_q <= reg_wdata_i;
      if (wr_hi) hi_q <= reg_wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_slot
    mbx_slot #(.MSG_W(MSG_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_i    (trig && id_q == ID_W'(g)),
      .fetch_i   (tgt_fetch_i[g]),
      .ovf_clr_i (wr_clr && reg_wdata_i[FLD_W+g]),
      .dlv_clr_i (wr_clr && reg_wdata_i[2*FLD_W+g]),
      .data_i    ({hi_q, lo_q}),
      .busy_o    (busy_vec[g]),
      .ovf_o     (ovf_vec[g]),
      .dlv_o     (dlv_vec[g]),
      .data_o    (tgt_data_o[g*MSG_W +: MSG_W]),
      .blk_ev_o  (blk_ev[g]),
      .ovf_ev_o  (ovf_ev[g]),
      .dlv_ev_o  (dlv_ev[g])
    );
  end

  assign evt.blk = |blk_ev;
  assign evt.ovf = |ovf_ev;
  assign evt.dlv = |dlv_ev;

  mbx_irq u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt),
    .mask_we_i    (wr_mask),
    .mask_wdata_i (mbx_evt_t'(reg_wdata_i[2:0])),
    .clr_i        (wr_ists),
    .mask_o       (mask_vec),
    .irq_o        (irq_o)
  );

  always_comb begin
    sts = '0;
    sts[0 +: NUM_TGT]       = busy_vec;
    sts[FLD_W +: NUM_TGT]   = ovf_vec;
    sts[2*FLD_W +: NUM_TGT] = dlv_vec;
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_W'(OFF_ID):   reg_rdata_o = DATA_W'(id_q);
      ADDR_W'(OFF_LO):   reg_rdata_o = lo_q;
      ADDR_W'(OFF_HI):   reg_rdata_o = hi_q;
      ADDR_W'(OFF_STS):  reg_rdata_o = sts;
      ADDR_W'(OFF_ISTS): reg_rdata_o = DATA_W'(irq_o);
      ADDR_W'(OFF_MASK): reg_rdata_o = DATA_W'({mask_vec});
      default:           reg_rdata_o = '0;
    endcase
  end

  assign tgt_valid_o = busy_vec;
endmodule

// File: rtl/mbx_send_ctrl_chk.sv
`timescale 1ns/1ps
module mbx_send_ctrl_chk
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_TGT = 8,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned ID_W    = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic               wdata0_i,
  input logic [NUM_TGT-1:0] tgt_valid_o,
  input logic [NUM_TGT-1:0] tgt_fetch_i,
  input logic               irq_o,
  input logic [ID_W-1:0]    id_q,
  input logic [NUM_TGT-1:0] ovf_vec,
  input logic [2:0]         mask_vec
);
  logic trig_w, iclr_w;
  assign trig_w = reg_we_i && reg_addr_i == ADDR_W'(OFF_TRIG) && wdata0_i;
  assign iclr_w = reg_we_i && reg_addr_i == ADDR_W'(OFF_ISTS) && wdata0_i;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (tgt_valid_o == '0 && !irq_o && mask_vec == 3'b111);
    end
  end

  a_r3_valid_needs_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_valid_o & ~$past(tgt_valid_o)) != '0 |-> $past(trig_w));

  a_r4_busy_trigger_overflows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_w && tgt_valid_o[id_q]) |=> ovf_vec[$past(id_q)]);

  a_r5_fetch_clears_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_valid_o & tgt_fetch_i) != '0 |=> (tgt_valid_o & $past(tgt_valid_o & tgt_fetch_i)) == '0);

  a_r8_irq_needs_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(mask_vec) != 3'b111);

  a_r9_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iclr_w && mask_vec == 3'b111) |=> !irq_o);
endmodule

bind mbx_send_ctrl mbx_send_ctrl_chk #(
  .NUM_TGT (NUM_TGT),
  .ADDR_W  (ADDR_W),
  .ID_W    (ID_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .wdata0_i    (reg_wdata_i[0]),
  .tgt_valid_o (tgt_valid_o),
  .tgt_fetch_i (tgt_fetch_i),
  .irq_o       (irq_o),
  .id_q        (id_q),
  .ovf_vec     (ovf_vec),
  .mask_vec    (mask_vec)
);

// File: tb/mbx_send_ctrl_bench.sv
`timescale 1ns/1ps
module mbx_send_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b1;
  logic         we = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [7:0]   valid;
  logic [511:0] tdata;
  logic [7:0]   fetch = '0;
  logic         irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbx_send_ctrl u_mbx_send_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tgt_valid_o(valid),
    .tgt_data_o(tdata), .tgt_fetch_i(fetch), .irq_o(irq)
  );

  // behavioural reference model
  logic [7:0]  m_busy, m_ovf, m_dlv;
  logic        m_irq;
  logic [2:0]  m_mask, m_id;
  logic [31:0] m_lo, m_hi;
  logic [63:0] m_data [8];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = '0; m_ovf = '0; m_dlv = '0; m_irq = 0; m_mask = 3'b111;
      m_id = '0; m_lo = '0; m_hi = '0;
      for (int k = 0; k < 8; k++) m_data[k] = '0;
    end else begin : upd
      logic [7:0] nb, no, nd;
      logic blk, oev, dev, trig;
      nb = m_busy; no = m_ovf; nd = m_dlv; blk = 0; oev = 0; dev = 0;
      trig = we && addr == 6'h0C && wdata[0];
      if (we && addr == 6'h10) begin
        no = no & ~wdata[15:8];
        nd = nd & ~wdata[23:16];
      end
      if (trig) begin
        if (m_busy[m_id]) begin
          blk = 1;
          if (!m_ovf[m_id]) oev = 1;
          no[m_id] = 1'b1;
        end else begin
          nb[m_id] = 1'b1;
          m_data[m_id] = {m_hi, m_lo};
        end
      end
      for (int k = 0; k < 8; k++)
        if (fetch[k] && m_busy[k]) begin nb[k] = 1'b0; nd[k] = 1'b1; dev = 1; end
      if (we && addr == 6'h18 && wdata[0]) m_irq = 0;
      if ((dev && !m_mask[2]) || (oev && !m_mask[1]) || (blk && !m_mask[0])) m_irq = 1;
      if (we && addr == 6'h00) m_id = wdata[2:0];
      if (we && addr == 6'h04) m_lo = wdata;
      if (we && addr == 6'h08) m_hi = wdata;
      if (we && addr == 6'h1C) m_mask = wdata[2:0];
      m_busy = nb; m_ovf = no; m_dlv = nd;
    end
  end

  function automatic logic [31:0] m_rd(input logic [5:0] a);
    case (a)
      6'h00: return {29'b0, m_id};
      6'h04: return m_lo;
      6'h08: return m_hi;
      6'h14: return {8'h00, m_dlv, m_ovf, m_busy};
      6'h18: return {31'b0, m_irq};
      6'h1C: return {29'b0, m_mask};
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // compare against model every clock
  always @(posedge clk) begin
    #1;
    if (rst_ni && !done) begin
      chk("R3 valid vs model", 64'(valid), 64'(m_busy));
      chk("R8 irq vs model", 64'(irq), 64'(m_irq));
      chk("R6 rdata vs model", 64'(rdata), 64'(m_rd(addr)));
      for (int k = 0; k < 8; k++) chk("R4 slot data vs model", tdata[k*64 +: 64], m_data[k]);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [7:0] f = 8'h00);
    @(negedge clk); addr = a; wdata = d; we = 1'b1; fetch = f;
    @(negedge clk); we = 1'b0; fetch = '0;
  endtask

  task automatic take(input logic [7:0] f);
    @(negedge clk); fetch = f;
    @(negedge clk); fetch = '0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, 64'(rdata), 64'(exp));
  endtask

  task automatic summary;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog R1: got timeout expected completion");
    summary();
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 irq at reset", 64'(irq), 0);
    chk("R1 valid at reset", 64'(valid), 0);
    rst_ni = 1'b1;
    rd(6'h1C, 32'h7, "R1 mask reset");
    rd(6'h14, 32'h0, "R1 status reset");
    rd(6'h18, 32'h0, "R1 irq status reset");
    rd(6'h00, 32'h0, "R1 id reset");

    wr(6'h04, 32'hA5A5_0001); wr(6'h08, 32'h5A5A_0002); wr(6'h00, 32'h3);
    rd(6'h04, 32'hA5A5_0001, "R2 low word");
    rd(6'h08, 32'h5A5A_0002, "R2 high word");
    rd(6'h00, 32'h3, "R2 id");
    wr(6'h1C, 32'h0);
    rd(6'h1C, 32'h0, "R2 mask");

    wr(6'h0C, 32'h0);
    rd(6'h14, 32'h0, "R3 trigger bit0 clear ignored");
    wr(6'h0C, 32'h1);
    chk("R3 valid after trigger", 64'(valid), 64'h08);
    chk("R3 slot 3 data", tdata[3*64 +: 64], 64'h5A5A_0002_A5A5_0001);
    chk("R8 no irq on accept", 64'(irq), 0);

    wr(6'h04, 32'hDEAD_0000); wr(6'h0C, 32'h1);
    chk("R4 dropped keeps data", tdata[3*64 +: 64], 64'h5A5A_0002_A5A5_0001);
    rd(6'h14, 32'h0000_0808, "R4 overflow set busy kept");
    chk("R8 irq on refusal", 64'(irq), 1);
    wr(6'h18, 32'h1);
    chk("R9 irq cleared", 64'(irq), 0);
    wr(6'h18, 32'h0);

    wr(6'h1C, 32'h5);
    wr(6'h0C, 32'h1);
    chk("R8 second refusal no overflow event", 64'(irq), 0);

    wr(6'h1C, 32'h3);
    take(8'h48);
    chk("R5 valid cleared by fetch", 64'(valid), 0);
    rd(6'h14, 32'h0008_0800, "R5 R6 status after fetch");
    chk("R8 irq on delivery", 64'(irq), 1);

    wr(6'h10, 32'h0008_0000);
    rd(6'h14, 32'h0000_0800, "R7 selective clear");
    wr(6'h18, 32'h1);

    wr(6'h00, 32'h1); wr(6'h0C, 32'h1);
    chk("R3 slot 1 accepted", 64'(valid), 64'h02);
    wr(6'h10, 32'h0002_0200, 8'h02);
    rd(6'h14, 32'h0002_0800, "R7 set wins over clear");

    wr(6'h00, 32'h2); wr(6'h0C, 32'h1);
    wr(6'h18, 32'h1, 8'h04);
    chk("R9 event wins over clear", 64'(irq), 1);
    rd(6'h14, 32'h0006_0800, "R6 status fields");

    wr(6'h18, 32'h1); wr(6'h1C, 32'h7);
    wr(6'h0C, 32'h1); take(8'h04);
    chk("R10 masked delivery", 64'(irq), 0);
    wr(6'h1C, 32'h0);
    chk("R10 unmask not retroactive", 64'(irq), 0);

    wr(6'h0C, 32'h1);
    wr(6'h04, 32'h1234_5678);
    wr(6'h0C, 32'h1, 8'h04);
    chk("R11 ends not busy", 64'(valid), 0);
    chk("R11 data kept", tdata[2*64 +: 64], 64'h5A5A_0002_DEAD_0000);
    rd(6'h14, 32'h0006_0C00, "R11 overflow and delivered");
    chk("R11 irq", 64'(irq), 1);

    wr(6'h10, 32'h00FF_FF00); wr(6'h18, 32'h1);
    for (int t = 0; t < 8; t++) begin
      wr(6'h04, 32'h0101_0101 * t);
      wr(6'h08, ~(32'h0101_0101 * t));
      wr(6'h00, 32'(t));
      wr(6'h0C, 32'h1);
    end
    chk("R3 all targets valid", 64'(valid), 64'hFF);
    for (int t = 0; t < 8; t++)
      chk("R3 per-target data", tdata[t*64 +: 64], {~(32'h0101_0101 * t), 32'h0101_0101 * t});
    take(8'hFF);
    rd(6'h14, 32'h00FF_0000, "R5 all delivered");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule